// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central scheduler of an out-of-order issue pipeline built around a few functional units. It does not compute anything itself. It keeps a status entry for every functional unit and a table that names, for every architectural register, the unit that will produce its next value. From that state it decides, cycle by cycle, four things: when a decoded instruction may be handed to a free unit, when a unit may fetch its operands, when it may begin executing, and when its result may be committed.

Each instruction moves through four steps in order. At issue, the controller checks for a free unit of the right class and for a pending writer of the same destination. At operand read, it waits until both sources have been produced. Execution is started one cycle after the read and lasts until the unit reports completion. At commit, it waits until no earlier instruction still needs the old value of the destination. No value is forwarded between units; a consumer always waits for the producer's commit.

The unit-to-class mapping arrives on an input, so the same block can serve any mix of unit kinds. The intended mix is two multipliers, one adder, one divider and one integer unit. Unit numbers start at 1, and 0 in the owner table means that no unit is producing the register.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After a synchronous reset, every grant and start output is low, every register owner reads 0, and `iss_stall` and `iss_take` are low while `in_valid` is low.
- R2: An accepted instruction goes to the lowest-numbered idle unit whose class code matches `in_class`. Class codes are 0 multiply, 1 add, 2 divide and 3 integer, and each unit's code sits in bits [2u+1:2u] of `unit_class`. `iss_unit` shows the chosen unit number (index+1) in the accept cycle, and from the next cycle the destination's owner field holds that number.
- R3: When every unit of the requested class is busy, `iss_stall` is high. The instruction is accepted in the cycle in which the first such unit's write grant is visible.
- R4: When the destination already has an owner, the instruction stalls. It is accepted in the cycle in which that owner's write grant is visible.
- R5: A unit whose operands are ready at issue pulses `rd_gnt` two cycles after the accept cycle and `ex_start` one cycle after `rd_gnt`.
- R6: A consumer of a pending register pulses `rd_gnt` one cycle after the producer's `wb_gnt`.
- R7: A finished unit is not granted a write while another unit has an enabled, ready and not yet read source equal to its destination. Its `wb_gnt` follows one cycle after that reader's `rd_gnt`.
- R8: At most one `wb_gnt` is high per cycle. A unit whose done pulse is accepted in cycle t may see `wb_gnt` in cycle t+2 at the earliest. When several units are eligible together, the lowest unit number is granted first.
- R9: In the cycle in which a unit's `wb_gnt` is visible, no register owner field names that unit, and the unit may accept a new instruction.
- R10: A source whose enable bit is low never delays the operand read and never blocks another unit's write.
- R11: A done pulse for a unit that is not executing has no effect: no write grant follows, and the unit later runs with normal timing.
- R12: An instruction accepted in the same cycle as its source producer's write-grant decision treats that source as ready, and its `rd_gnt` comes two cycles after the accept cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_class | input | NUM_UNITS*CLS_W | Class code of each unit |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | CLS_W | Class of operation needed |
| in_dst | input | RID_W | Destination register |
| in_src1 | input | RID_W | First source register |
| in_src1_en | input | 1 | First source is used |
| in_src2 | input | RID_W | Second source register |
| in_src2_en | input | 1 | Second source is used |
| exe_done | input | NUM_UNITS | Per-unit execution-complete pulse |
| iss_take | output | 1 | Instruction accepted this cycle |
| iss_stall | output | 1 | Instruction present but held |
| iss_unit | output | OWN_W | Unit number chosen (0 when none) |
| rd_gnt | output | NUM_UNITS | Operand-read grant pulse per unit |
| ex_start | output | NUM_UNITS | Execution-start pulse per unit |
| wb_gnt | output | NUM_UNITS | Result-write grant pulse per unit |
| reg_owner | output | NUM_REGS*OWN_W | Producing unit of each register |

## Verification
The bound checker watches, on every cycle, the properties that hold locally: there is at most one write grant at a time, a start pulse always follows a read grant, an accepted destination gets its owner recorded, an owned destination is never accepted, and a committing unit is gone from the owner table. The ordering relations between instructions can only be seen in the bench's scenarios. These include the read-after-write delay, the write held back by a pending reader, the release of a unit to a stalled instruction, priority between units finishing together, disabled sources, stray done pulses and the same-cycle source release. The bench compares them against cycle numbers it derives from the pipeline's fixed latencies.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT_OPS,
    PH_READ,
    PH_EXEC,
    PH_WB_REQ
  } sb_phase_e;

  localparam int unsigned CLS_MUL = 0;
  localparam int unsigned CLS_ADD = 1;
  localparam int unsigned CLS_DIV = 2;
  localparam int unsigned CLS_INT = 3;
endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
  import sb_pkg::*;
#(
  parameter int RID_W = 4,
  parameter int OWN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_we,
  input  logic [RID_W-1:0] iss_fi,
  input  logic [RID_W-1:0] iss_fj,
  input  logic [RID_W-1:0] iss_fk,
  input  logic             iss_uj,
  input  logic             iss_uk,
  input  logic [OWN_W-1:0] iss_qj,
  input  logic [OWN_W-1:0] iss_qk,
  input  logic             wb_any,
  input  logic [OWN_W-1:0] wb_code,
  input  logic             exe_done,
  input  logic             wb_win,
  output logic             busy,
  output logic             wb_req,
  output logic [RID_W-1:0] fi,
  output logic [RID_W-1:0] fj,
  output logic [RID_W-1:0] fk,
  output logic             uj,
  output logic             uk,
  output logic             rj,
  output logic             rk,
  output logic             rd_pulse,
  output logic             st_pulse,
  output logic             wb_pulse
);
  sb_phase_e        phase;
  logic [OWN_W-1:0] qj, qk;

  assign busy   = (phase != PH_IDLE);
  assign wb_req = (phase == PH_WB_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      fi       <= '0;
      fj       <= '0;
      fk       <= '0;
      uj       <= 1'b0;
      uk       <= 1'b0;
      qj       <= '0;
      qk       <= '0;
      rj       <= 1'b0;
      rk       <= 1'b0;
      rd_pulse <= 1'b0;
      st_pulse <= 1'b0;
      wb_pulse <= 1'b0;
    end else begin
      rd_pulse <= 1'b0;
      st_pulse <= 1'b0;
      wb_pulse <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (iss_we) begin
            phase <= PH_WAIT_OPS;
            fi    <= iss_fi;
            fj    <= iss_fj;
            fk    <= iss_fk;
            uj    <= iss_uj;
            uk    <= iss_uk;
            qj    <= iss_qj;
            qk    <= iss_qk;
            rj    <= (iss_qj == '0);
            rk    <= (iss_qk == '0);
          end
        end
        PH_WAIT_OPS: begin
          if (rj && rk) begin
            rj       <= 1'b0;
            rk       <= 1'b0;
            rd_pulse <= 1'b1;
            phase    <= PH_READ;
          end else begin
            if (wb_any && !rj && (qj == wb_code)) begin
              rj <= 1'b1;
              qj <= '0;
            end
            if (wb_any && !rk && (qk == wb_code)) begin
              rk <= 1'b1;
              qk <= '0;
            end
          end
        end
        PH_READ: begin
          st_pulse <= 1'b1;
          phase    <= PH_EXEC;
        end
        PH_EXEC: begin
          if (exe_done) phase <= PH_WB_REQ;
        end
        PH_WB_REQ: begin
          if (wb_win) begin
            wb_pulse <= 1'b1;
            phase    <= PH_IDLE;
            uj       <= 1'b0;
            uk       <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int NUM_UNITS = 5,
  parameter int RID_W     = 4,
  parameter int OWN_W     = 3
) (
  input  logic [NUM_UNITS-1:0]       req,
  input  logic [NUM_UNITS*RID_W-1:0] fi_flat,
  input  logic [NUM_UNITS*RID_W-1:0] fj_flat,
  input  logic [NUM_UNITS*RID_W-1:0] fk_flat,
  input  logic [NUM_UNITS-1:0]       uj,
  input  logic [NUM_UNITS-1:0]       uk,
  input  logic [NUM_UNITS-1:0]       rj,
  input  logic [NUM_UNITS-1:0]       rk,
  output logic [NUM_UNITS-1:0]       win,
  output logic                       wb_any,
  output logic [OWN_W-1:0]           wb_code,
  output logic [RID_W-1:0]           wb_fi
);
  logic [NUM_UNITS-1:0] war_clear;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      war_clear[u] = 1'b1;
      for (int f = 0; f < NUM_UNITS; f++) begin
        if (uj[f] && rj[f] && (fj_flat[f*RID_W +: RID_W] == fi_flat[u*RID_W +: RID_W]))
          war_clear[u] = 1'b0;
        if (uk[f] && rk[f] && (fk_flat[f*RID_W +: RID_W] == fi_flat[u*RID_W +: RID_W]))
          war_clear[u] = 1'b0;
      end
    end
  end

  always_comb begin
    win     = '0;
    wb_any  = 1'b0;
    wb_code = '0;
    wb_fi   = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!wb_any && req[u] && war_clear[u]) begin
        wb_any  = 1'b1;
        win[u]  = 1'b1;
        wb_code = OWN_W'(u + 1);
        wb_fi   = fi_flat[u*RID_W +: RID_W];
      end
    end
  end
endmodule

// File: rtl/sb_owner_table.sv
module sb_owner_table #(
  parameter int NUM_REGS = 16,
  parameter int RID_W    = 4,
  parameter int OWN_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_en,
  input  logic [RID_W-1:0]          set_idx,
  input  logic [OWN_W-1:0]          set_code,
  input  logic                      clr_en,
  input  logic [RID_W-1:0]          clr_idx,
  input  logic [RID_W-1:0]          rd_a,
  input  logic [RID_W-1:0]          rd_b,
  input  logic [RID_W-1:0]          rd_c,
  output logic [OWN_W-1:0]          own_a,
  output logic [OWN_W-1:0]          own_b,
  output logic [OWN_W-1:0]          own_c,
  output logic [NUM_REGS*OWN_W-1:0] own_flat
);
  logic [OWN_W-1:0] tbl [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) tbl[r] <= '0;
    end else begin
      if (clr_en) tbl[clr_idx] <= '0;
      if (set_en) tbl[set_idx] <= set_code;
    end
  end

  assign own_a = tbl[rd_a];
  assign own_b = tbl[rd_b];
  assign own_c = tbl[rd_c];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_flat
    assign own_flat[r*OWN_W +: OWN_W] = tbl[r];
  end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl #(
  parameter int NUM_UNITS = 5,
  parameter int NUM_REGS  = 16,
  parameter int CLS_W     = 2,
  localparam int RID_W    = $clog2(NUM_REGS),
  localparam int OWN_W    = $clog2(NUM_UNITS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_UNITS*CLS_W-1:0] unit_class,
  input  logic                      in_valid,
  input  logic [CLS_W-1:0]          in_class,
  input  logic [RID_W-1:0]          in_dst,
  input  logic [RID_W-1:0]          in_src1,
  input  logic                      in_src1_en,
  input  logic [RID_W-1:0]          in_src2,
  input  logic                      in_src2_en,
  input  logic [NUM_UNITS-1:0]      exe_done,
  output logic                      iss_take,
  output logic                      iss_stall,
  output logic [OWN_W-1:0]          iss_unit,
  output logic [NUM_UNITS-1:0]      rd_gnt,
  output logic [NUM_UNITS-1:0]      ex_start,
  output logic [NUM_UNITS-1:0]      wb_gnt,
  output logic [NUM_REGS*OWN_W-1:0] reg_owner
);
  logic [NUM_UNITS-1:0]       busy, wb_req, win, iss_we;
  logic [NUM_UNITS-1:0]       uj, uk, rj, rk;
  logic [NUM_UNITS*RID_W-1:0] fi_flat, fj_flat, fk_flat;
  logic                       wb_any;
  logic [OWN_W-1:0]           wb_code;
  logic [RID_W-1:0]           wb_fi;
  logic [OWN_W-1:0]           dst_own, s1_own, s2_own;
  logic [OWN_W-1:0]           qj_in, qk_in, pick_code;
  logic                       pick_ok;

  // lowest idle unit of the requested class
  always_comb begin
    pick_ok   = 1'b0;
    pick_code = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!pick_ok && !busy[u] && (unit_class[u*CLS_W +: CLS_W] == in_class)) begin
        pick_ok   = 1'b1;
        pick_code = OWN_W'(u + 1);
      end
    end
  end

  assign iss_take  = in_valid && pick_ok && (dst_own == '0);
  assign iss_stall = in_valid && !iss_take;
  assign iss_unit  = iss_take ? pick_code : '0;

  // a producer committing this cycle counts as already done
  assign qj_in = (!in_src1_en || (wb_any && (s1_own == wb_code))) ? '0 : s1_own;
  assign qk_in = (!in_src2_en || (wb_any && (s2_own == wb_code))) ? '0 : s2_own;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign iss_we[u] = iss_take && (pick_code == OWN_W'(u + 1));

    sb_unit_entry #(.RID_W(RID_W), .OWN_W(OWN_W)) u_entry (
      .clk      (clk),
      .rst      (rst),
      .iss_we   (iss_we[u]),
      .iss_fi   (in_dst),
      .iss_fj   (in_src1),
      .iss_fk   (in_src2),
      .iss_uj   (in_src1_en),
      .iss_uk   (in_src2_en),
      .iss_qj   (qj_in),
      .iss_qk   (qk_in),
      .wb_any   (wb_any),
      .wb_code  (wb_code),
      .exe_done (exe_done[u]),
      .wb_win   (win[u]),
      .busy     (busy[u]),
      .wb_req   (wb_req[u]),
      .fi       (fi_flat[u*RID_W +: RID_W]),
      .fj       (fj_flat[u*RID_W +: RID_W]),
      .fk       (fk_flat[u*RID_W +: RID_W]),
      .uj       (uj[u]),
      .uk       (uk[u]),
      .rj       (rj[u]),
      .rk       (rk[u]),
      .rd_pulse (rd_gnt[u]),
      .st_pulse (ex_start[u]),
      .wb_pulse (wb_gnt[u])
    );
  end

  sb_wb_arbiter #(.NUM_UNITS(NUM_UNITS), .RID_W(RID_W), .OWN_W(OWN_W)) u_arb (
    .req     (wb_req),
    .fi_flat (fi_flat),
    .fj_flat (fj_flat),
    .fk_flat (fk_flat),
    .uj      (uj),
    .uk      (uk),
    .rj      (rj),
    .rk      (rk),
    .win     (win),
    .wb_any  (wb_any),
    .wb_code (wb_code),
    .wb_fi   (wb_fi)
  );

  sb_owner_table #(.NUM_REGS(NUM_REGS), .RID_W(RID_W), .OWN_W(OWN_W)) u_own (
    .clk      (clk),
    .rst      (rst),
    .set_en   (iss_take),
    .set_idx  (in_dst),
    .set_code (pick_code),
    .clr_en   (wb_any),
    .clr_idx  (wb_fi),
    .rd_a     (in_dst),
    .rd_b     (in_src1),
    .rd_c     (in_src2),
    .own_a    (dst_own),
    .own_b    (s1_own),
    .own_c    (s2_own),
    .own_flat (reg_owner)
  );
endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
module sb_hazard_ctrl_chk #(
  parameter int NUM_UNITS = 5,
  parameter int NUM_REGS  = 16,
  parameter int RID_W     = 4,
  parameter int OWN_W     = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [RID_W-1:0]          in_dst,
  input logic                      iss_take,
  input logic [OWN_W-1:0]          iss_unit,
  input logic [NUM_UNITS-1:0]      rd_gnt,
  input logic [NUM_UNITS-1:0]      ex_start,
  input logic [NUM_UNITS-1:0]      wb_gnt,
  input logic [NUM_REGS*OWN_W-1:0] reg_owner
);
  logic [OWN_W-1:0] own_arr [NUM_REGS];
  logic [OWN_W-1:0] wb_code_seen;
  logic             wb_still_owns;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_own
    assign own_arr[r] = reg_owner[r*OWN_W +: OWN_W];
  end

  always_comb begin
    wb_code_seen = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (wb_gnt[u]) wb_code_seen = OWN_W'(u + 1);
    wb_still_owns = 1'b0;
    for (int r = 0; r < NUM_REGS; r++)
      if (own_arr[r] == wb_code_seen) wb_still_owns = 1'b1;
  end

  a_r8_single_wb: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wb_gnt));

  a_r5_start_after_read: assert property (@(posedge clk) disable iff (rst)
    (ex_start & ~$past(rd_gnt)) == '0);

  a_r2_owner_recorded: assert property (@(posedge clk) disable iff (rst)
    iss_take |=> own_arr[$past(in_dst)] == $past(iss_unit));

  a_r4_waw_held: assert property (@(posedge clk) disable iff (rst)
    (in_valid && own_arr[in_dst] != '0) |-> !iss_take);

  a_r3_take_names_unit: assert property (@(posedge clk) disable iff (rst)
    iss_take |-> iss_unit != '0);

  a_r9_owner_released: assert property (@(posedge clk) disable iff (rst)
    (wb_gnt != '0) |-> !wb_still_owns);
endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk #(
  .NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .RID_W(RID_W), .OWN_W(OWN_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
  .iss_take(iss_take), .iss_unit(iss_unit), .rd_gnt(rd_gnt),
  .ex_start(ex_start), .wb_gnt(wb_gnt), .reg_owner(reg_owner)
);

// File: tb/sb_hazard_ctrl_tb.sv
module sb_hazard_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 5;
  localparam int NR = 16;
  localparam int RW = 4;
  localparam int OW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NU*2-1:0] unit_class;
  logic          in_valid = 1'b0;
  logic [1:0]    in_class = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic          in_src1_en = 1'b0, in_src2_en = 1'b0;
  logic [NU-1:0] auto_done = '0, man_done = '0, exe_done;
  logic          iss_take, iss_stall;
  logic [OW-1:0] iss_unit;
  logic [NU-1:0] rd_gnt, ex_start, wb_gnt;
  logic [NR*OW-1:0] reg_owner;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int lat [NU];
  int cd  [NU];
  int rd_at [NU];
  int st_at [NU];
  int wb_at [NU];

  // units 1,2 multiply; 3 add; 4 divide; 5 integer
  assign unit_class = {2'd3, 2'd2, 2'd1, 2'd0, 2'd0};
  assign exe_done   = auto_done | man_done;

  sb_hazard_ctrl u_dut (
    .clk(clk), .rst(rst), .unit_class(unit_class), .in_valid(in_valid),
    .in_class(in_class), .in_dst(in_dst), .in_src1(in_src1),
    .in_src1_en(in_src1_en), .in_src2(in_src2), .in_src2_en(in_src2_en),
    .exe_done(exe_done), .iss_take(iss_take), .iss_stall(iss_stall),
    .iss_unit(iss_unit), .rd_gnt(rd_gnt), .ex_start(ex_start),
    .wb_gnt(wb_gnt), .reg_owner(reg_owner)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // event recorder and per-unit execution latency model
  always @(negedge clk) begin
    for (int u = 0; u < NU; u++) begin
      if (rd_gnt[u]) rd_at[u] = cyc;
      if (ex_start[u]) st_at[u] = cyc;
      if (wb_gnt[u]) wb_at[u] = cyc;
      auto_done[u] = 1'b0;
      if (cd[u] > 0) begin
        cd[u] = cd[u] - 1;
        if (cd[u] == 0) auto_done[u] = 1'b1;
      end
      if (ex_start[u]) cd[u] = lat[u];
    end
  end

  function automatic int owner_of(input int r);
    return int'(reg_owner[r*OW +: OW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int u = 0; u < NU; u++) begin
      rd_at[u] = -1; st_at[u] = -1; wb_at[u] = -1; lat[u] = 1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input int cls, input int dst, input int s1, input bit e1,
                       input int s2, input bit e2, output int at, output int unit);
    @(negedge clk);
    in_valid = 1'b1; in_class = 2'(cls); in_dst = RW'(dst);
    in_src1 = RW'(s1); in_src1_en = e1; in_src2 = RW'(s2); in_src2_en = e2;
    #1;
    while (!iss_take) begin
      @(negedge clk);
      #1;
    end
    at = cyc; unit = int'(iss_unit);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rd_gnt", int'(rd_gnt), 0);
    chk("R1 ex_start", int'(ex_start), 0);
    chk("R1 wb_gnt", int'(wb_gnt), 0);
    chk("R1 owners", int'(reg_owner != '0), 0);
    chk("R1 stall idle", int'(iss_stall), 0);
    chk("R1 take idle", int'(iss_take), 0);
  endtask

  task automatic t_independent();
    int a, u;
    clear_log();
    issue(1, 1, 2, 1, 3, 1, a, u);
    chk("R2 add unit", u, 3);
    @(negedge clk);
    chk("R2 owner r1", owner_of(1), 3);
    idle(10);
    chk("R5 read at +2", rd_at[2], a + 2);
    chk("R5 start at +3", st_at[2], a + 3);
    chk("R8 wb at +6", wb_at[2], a + 6);
    chk("R9 owner r1 cleared", owner_of(1), 0);
  endtask

  task automatic t_raw();
    int a, b, u;
    clear_log();
    lat[0] = 3;
    issue(0, 4, 1, 1, 2, 1, a, u);
    issue(1, 5, 4, 1, 1, 1, b, u);
    idle(16);
    chk("R6 producer wb", wb_at[0], a + 8);
    chk("R6 consumer read", rd_at[2], wb_at[0] + 1);
    chk("R5 consumer start", st_at[2], rd_at[2] + 1);
  endtask

  task automatic t_waw();
    int a, b, u;
    clear_log();
    lat[0] = 3;
    issue(0, 6, 1, 1, 2, 1, a, u);
    @(negedge clk);
    in_valid = 1'b1; in_class = 2'd1; in_dst = 4'd6;
    in_src1_en = 1'b0; in_src2_en = 1'b0;
    #1;
    chk("R4 waw stall", int'(iss_stall), 1);
    in_valid = 1'b0;
    issue(1, 6, 0, 0, 0, 0, b, u);
    chk("R4 accept at owner wb", b, a + 8);
    @(negedge clk);
    chk("R4 new owner", owner_of(6), 3);
    idle(10);
  endtask

  task automatic t_war();
    int a, b, c, u;
    clear_log();
    lat[0] = 5;
    issue(0, 10, 1, 1, 2, 1, a, u);
    issue(2, 9, 10, 1, 8, 1, b, u);
    issue(1, 8, 2, 1, 3, 1, c, u);
    idle(20);
    chk("R7 reader read", rd_at[3], a + 11);
    chk("R7 writer held", wb_at[2], rd_at[3] + 1);
  endtask

  task automatic t_priority();
    int a, b, u;
    clear_log();
    lat[2] = 2;
    lat[4] = 1;
    issue(1, 1, 2, 1, 3, 1, a, u);
    issue(3, 2, 3, 1, 4, 1, b, u);
    idle(12);
    chk("R8 low unit first", wb_at[2], a + 7);
    chk("R8 next unit after", wb_at[4], a + 8);
  endtask

  task automatic t_structural();
    int a, b, c, u1, u2, u3;
    clear_log();
    lat[0] = 3;
    lat[1] = 6;
    issue(0, 1, 0, 0, 0, 0, a, u1);
    issue(0, 2, 0, 0, 0, 0, b, u2);
    chk("R2 second mul unit", u2, 2);
    issue(0, 3, 0, 0, 0, 0, c, u3);
    chk("R3 accept at free", c, a + 8);
    chk("R3 reuse unit", u3, 1);
    idle(16);
  endtask

  task automatic t_unused();
    int a, b, u;
    clear_log();
    lat[0] = 4;
    issue(0, 12, 1, 1, 2, 1, a, u);
    issue(1, 13, 12, 0, 2, 1, b, u);
    idle(14);
    chk("R10 no wait on disabled", rd_at[2], b + 2);
    chk("R10 producer not blocked", wb_at[0], a + 9);
  endtask

  task automatic t_stray_done();
    int a, u;
    clear_log();
    @(negedge clk);
    man_done[3] = 1'b1;
    @(negedge clk);
    man_done[3] = 1'b0;
    idle(6);
    chk("R11 no wb from stray", wb_at[3], -1);
    issue(2, 5, 1, 1, 2, 1, a, u);
    idle(10);
    chk("R11 normal start", st_at[3], a + 3);
    chk("R11 normal wb", wb_at[3], a + 6);
  endtask

  task automatic t_same_cycle();
    int a, b, u;
    clear_log();
    issue(1, 14, 1, 1, 2, 1, a, u);
    while (cyc < a + 4) @(negedge clk);
    issue(3, 15, 14, 1, 0, 0, b, u);
    chk("R12 accept cycle", b, a + 5);
    @(negedge clk);
    chk("R12 owner r15", owner_of(15), 5);
    chk("R12 owner r14 gone", owner_of(14), 0);
    idle(8);
    chk("R12 read immediate", rd_at[4], b + 2);
  endtask

  initial begin
    clear_log();
    for (int u = 0; u < NU; u++) cd[u] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_independent();
    t_raw();
    t_waw();
    t_war();
    t_priority();
    t_structural();
    t_unused();
    t_stray_done();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule